// File: doc/BRIEF.md
# Pipelined Overlap Resolver for Parallel String Matches

This block sits after a parallel string matcher in a streaming compressor. Every cycle it may accept one window of `PWS` positions. For each position it gets the literal byte there, a candidate back-reference (length and offset) and a flag that says whether the candidate exists. It settles which candidates survive so that the window turns into a sequence of literals and back-references that do not overlap. Each position then carries one tag saying it is covered by an earlier match, it is a literal, or it starts a match.

The first stage shortens every candidate so that it ends inside the window. A candidate shorter than the minimum usable length of four bytes after this step is dropped. Then `PWS` stages follow, and each one decides exactly one position. A countdown of positions still covered by the last chosen match travels down the pipe with the window. A stage whose countdown is zero makes a fresh choice. It defers its own match in favour of the next position when that position's shortened match is strictly longer. Windows are independent and may arrive back to back. Results leave the block a fixed number of cycles after they enter.

Top module: `lzsel_top`

## Requirements
- R1: A candidate at position i is shortened to at most `PWS - i` bytes, so no emitted match runs past the end of its window.
- R2: A position whose flag is clear, or whose shortened length is below 4, is never tagged as a match. When it is not covered by an earlier match, it is tagged as a literal.
- R3: The covering countdown starts at zero for every window. Position 0 is never tagged as covered, even when the previous window ended inside a match.
- R4: After a match of length L is chosen at position i, positions i+1 to i+L-1 are tagged as covered, and position i+L makes a fresh choice.
- R5: An uncovered position with a usable match is tagged as a literal if the next position's shortened length is strictly greater. Otherwise, on a tie or a shorter next match, it takes its own match. The last position has no next position to compare with.
- R6: Tag codes per position are 2 bits: 0 = covered, 1 = literal, 2 = match. A match reports its shortened length and its offset. Covered and literal positions report length 0 and offset 0. The literal byte is passed through for every position.
- R7: `out_valid` pulses for one cycle per accepted window, exactly `PWS + 1` cycles after the cycle in which `in_valid` was high. Windows on consecutive cycles come out on consecutive cycles, in order.
- R8: While `rst` is high and in the cycle after it, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A window is present this cycle |
| in_lit | input | PWS*8 | Literal byte per position |
| in_len | input | PWS*LEN_W | Candidate match length per position |
| in_off | input | PWS*OFF_W | Candidate match offset per position |
| in_mvalid | input | PWS | Candidate exists at the position |
| out_valid | output | 1 | Resolved window present |
| out_tag | output | PWS*2 | Per-position tag (0 covered, 1 literal, 2 match) |
| out_len | output | PWS*LEN_W | Emitted match length, 0 unless tag is match |
| out_off | output | PWS*OFF_W | Emitted match offset, 0 unless tag is match |
| out_lit | output | PWS*8 | Literal byte per position |

## Verification
The bench targets a candidate that overshoots the window end. A resolver that skipped the shortening would emit a match longer than the bytes that remain. It also drives a shortened candidate that falls to two bytes, which a design that tested the minimum before trimming would wrongly accept. Two windows are sent back to back, the first ending inside a match. A countdown that leaked across windows would mark the second window's first position as covered. The lazy rule is probed with a strictly longer next match and with an equal one, to catch a comparison that uses the wrong sense or the untrimmed lengths. A burst of pseudo-random windows exposes off-by-one errors in the countdown, where one position too many or too few would be covered.

// File: rtl/lzsel_pkg.sv
package lzsel_pkg;

    typedef enum logic [1:0] {
        TAG_COVERED = 2'd0,
        TAG_LITERAL = 2'd1,
        TAG_MATCH   = 2'd2
    } tag_e;

    localparam int unsigned MIN_MATCH = 4;

    function automatic int unsigned clip_len(input int unsigned len, input int unsigned room);
        return (len > room) ? room : len;
    endfunction

    function automatic int unsigned usable_len(input int unsigned len, input int unsigned room,
                                               input logic present);
        int unsigned c;
        c = clip_len(len, room);
        return (present && c >= MIN_MATCH) ? c : 0;
    endfunction

endpackage

// File: rtl/lzsel_trim.sv
module lzsel_trim
    import lzsel_pkg::*;
#(
    parameter int PWS   = 8,
    parameter int LEN_W = 6,
    parameter int OFF_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [PWS-1:0][7:0]        in_lit,
    input  logic [PWS-1:0][LEN_W-1:0]  in_len,
    input  logic [PWS-1:0][OFF_W-1:0]  in_off,
    input  logic [PWS-1:0]             in_mvalid,
    output logic                       o_vld,
    output logic [LEN_W-1:0]           o_cnt,
    output logic [PWS-1:0][LEN_W-1:0]  o_tlen,
    output logic [PWS-1:0][OFF_W-1:0]  o_off,
    output logic [PWS-1:0][7:0]        o_lit,
    output logic [PWS-1:0][1:0]        o_tag
);

    logic [PWS-1:0][LEN_W-1:0] tlen_c;

    // shorten each candidate to the bytes left in the window, drop short ones
    always_comb begin
        for (int i = 0; i < PWS; i++) begin
            tlen_c[i] = LEN_W'(usable_len(32'(in_len[i]), 32'(PWS - i), in_mvalid[i]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_vld  <= 1'b0;
            o_tlen <= '0;
            o_off  <= '0;
            o_lit  <= '0;
        end else begin
            o_vld  <= in_valid;
            o_tlen <= tlen_c;
            o_off  <= in_off;
            o_lit  <= in_lit;
        end
    end

    // every window starts with no coverage from before
    assign o_cnt = '0;
    assign o_tag = '0;

endmodule

// File: rtl/lzsel_stage.sv
module lzsel_stage
    import lzsel_pkg::*;
#(
    parameter int PWS   = 8,
    parameter int LEN_W = 6,
    parameter int OFF_W = 16,
    parameter int POS   = 0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       i_vld,
    input  logic [LEN_W-1:0]           i_cnt,
    input  logic [PWS-1:0][LEN_W-1:0]  i_tlen,
    input  logic [PWS-1:0][OFF_W-1:0]  i_off,
    input  logic [PWS-1:0][7:0]        i_lit,
    input  logic [PWS-1:0][1:0]        i_tag,
    output logic                       o_vld,
    output logic [LEN_W-1:0]           o_cnt,
    output logic [PWS-1:0][LEN_W-1:0]  o_tlen,
    output logic [PWS-1:0][OFF_W-1:0]  o_off,
    output logic [PWS-1:0][7:0]        o_lit,
    output logic [PWS-1:0][1:0]        o_tag
);

    localparam bit HAS_NXT = (POS < PWS - 1);
    localparam int NXT     = HAS_NXT ? POS + 1 : POS;

    tag_e             sel;
    logic [LEN_W-1:0] cnt_n;
    logic             defer;

    assign defer = HAS_NXT && (i_tlen[NXT] > i_tlen[POS]);

    always_comb begin
        if (i_cnt != '0) begin
            sel   = TAG_COVERED;
            cnt_n = i_cnt - LEN_W'(1);
        end else if (i_tlen[POS] == '0 || defer) begin
            sel   = TAG_LITERAL;
            cnt_n = '0;
        end else begin
            sel   = TAG_MATCH;
            cnt_n = i_tlen[POS] - LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_vld  <= 1'b0;
            o_cnt  <= '0;
            o_tlen <= '0;
            o_off  <= '0;
            o_lit  <= '0;
            o_tag  <= '0;
        end else begin
            o_vld  <= i_vld;
            o_cnt  <= cnt_n;
            o_lit  <= i_lit;
            o_tlen <= i_tlen;
            o_off  <= i_off;
            o_tag  <= i_tag;
            o_tag[POS] <= sel;
            if (sel != TAG_MATCH) begin
                o_tlen[POS] <= '0;
                o_off[POS]  <= '0;
            end
        end
    end

endmodule

// File: rtl/lzsel_top.sv
module lzsel_top
    import lzsel_pkg::*;
#(
    parameter int PWS   = 8,
    parameter int LEN_W = 6,
    parameter int OFF_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [PWS-1:0][7:0]        in_lit,
    input  logic [PWS-1:0][LEN_W-1:0]  in_len,
    input  logic [PWS-1:0][OFF_W-1:0]  in_off,
    input  logic [PWS-1:0]             in_mvalid,
    output logic                       out_valid,
    output logic [PWS-1:0][1:0]        out_tag,
    output logic [PWS-1:0][LEN_W-1:0]  out_len,
    output logic [PWS-1:0][OFF_W-1:0]  out_off,
    output logic [PWS-1:0][7:0]        out_lit
);

    localparam int DEPTH = PWS + 1;

    logic                       c_vld  [DEPTH];
    logic [LEN_W-1:0]           c_cnt  [DEPTH];
    logic [PWS-1:0][LEN_W-1:0]  c_tlen [DEPTH];
    logic [PWS-1:0][OFF_W-1:0]  c_off  [DEPTH];
    logic [PWS-1:0][7:0]        c_lit  [DEPTH];
    logic [PWS-1:0][1:0]        c_tag  [DEPTH];

    lzsel_trim #(.PWS(PWS), .LEN_W(LEN_W), .OFF_W(OFF_W)) u_trim (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_lit(in_lit), .in_len(in_len),
        .in_off(in_off), .in_mvalid(in_mvalid),
        .o_vld(c_vld[0]), .o_cnt(c_cnt[0]), .o_tlen(c_tlen[0]),
        .o_off(c_off[0]), .o_lit(c_lit[0]), .o_tag(c_tag[0])
    );

    for (genvar k = 0; k < PWS; k++) begin : g_stage
        lzsel_stage #(.PWS(PWS), .LEN_W(LEN_W), .OFF_W(OFF_W), .POS(k)) u_st (
            .clk(clk), .rst(rst),
            .i_vld(c_vld[k]), .i_cnt(c_cnt[k]), .i_tlen(c_tlen[k]),
            .i_off(c_off[k]), .i_lit(c_lit[k]), .i_tag(c_tag[k]),
            .o_vld(c_vld[k+1]), .o_cnt(c_cnt[k+1]), .o_tlen(c_tlen[k+1]),
            .o_off(c_off[k+1]), .o_lit(c_lit[k+1]), .o_tag(c_tag[k+1])
        );
    end

    logic [LEN_W-1:0] spent_cnt;
    assign spent_cnt = c_cnt[PWS];

    assign out_valid = c_vld[PWS];
    assign out_tag   = c_tag[PWS];
    assign out_len   = c_tlen[PWS];
    assign out_off   = c_off[PWS];
    assign out_lit   = c_lit[PWS];

endmodule

// File: rtl/lzsel_checker.sv
module lzsel_checker
    import lzsel_pkg::*;
#(
    parameter int PWS   = 8,
    parameter int LEN_W = 6,
    parameter int OFF_W = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       in_valid,
    input logic                       out_valid,
    input logic [PWS-1:0][1:0]        out_tag,
    input logic [PWS-1:0][LEN_W-1:0]  out_len,
    input logic [PWS-1:0][OFF_W-1:0]  out_off
);

    logic [PWS:0] seen;

    always_ff @(posedge clk) begin
        if (rst) seen <= '0;
        else     seen <= {seen[PWS-1:0], in_valid};
    end

    assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid == seen[PWS]);

    assert_first_open_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_tag[0] != 2'(TAG_COVERED));

    for (genvar i = 0; i < PWS; i++) begin : g_pos
        assert_min_len_R2: assert property (@(posedge clk) disable iff (rst)
            (out_valid && out_tag[i] == 2'(TAG_MATCH)) |-> out_len[i] >= LEN_W'(MIN_MATCH));

        assert_in_window_R1: assert property (@(posedge clk) disable iff (rst)
            (out_valid && out_tag[i] == 2'(TAG_MATCH)) |-> out_len[i] <= LEN_W'(PWS - i));

        assert_quiet_fields_R6: assert property (@(posedge clk) disable iff (rst)
            (out_valid && out_tag[i] != 2'(TAG_MATCH)) |-> (out_len[i] == '0 && out_off[i] == '0));

        assert_tag_code_R6: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> out_tag[i] != 2'd3);

        if (i < PWS - 1) begin : g_pair
            assert_cover_next_R4: assert property (@(posedge clk) disable iff (rst)
                (out_valid && out_tag[i] == 2'(TAG_MATCH) && out_len[i] > LEN_W'(1))
                    |-> out_tag[i+1] == 2'(TAG_COVERED));

            assert_cover_origin_R4: assert property (@(posedge clk) disable iff (rst)
                (out_valid && out_tag[i+1] == 2'(TAG_COVERED))
                    |-> out_tag[i] != 2'(TAG_LITERAL));
        end
    end

endmodule

bind lzsel_top lzsel_checker #(.PWS(PWS), .LEN_W(LEN_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
    .out_tag(out_tag), .out_len(out_len), .out_off(out_off)
);

// File: tb/lzsel_top_tb.sv
`timescale 1ns/1ps
module lzsel_top_tb;

    localparam int PWS   = 8;
    localparam int LEN_W = 6;
    localparam int OFF_W = 16;
    localparam int LAT   = PWS + 1;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic                       in_valid = 1'b0;
    logic [PWS-1:0][7:0]        in_lit = '0;
    logic [PWS-1:0][LEN_W-1:0]  in_len = '0;
    logic [PWS-1:0][OFF_W-1:0]  in_off = '0;
    logic [PWS-1:0]             in_mvalid = '0;
    logic                       out_valid;
    logic [PWS-1:0][1:0]        out_tag;
    logic [PWS-1:0][LEN_W-1:0]  out_len;
    logic [PWS-1:0][OFF_W-1:0]  out_off;
    logic [PWS-1:0][7:0]        out_lit;

    always #4 clk = ~clk;

    lzsel_top #(.PWS(PWS), .LEN_W(LEN_W), .OFF_W(OFF_W)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_lit(in_lit),
        .in_len(in_len), .in_off(in_off), .in_mvalid(in_mvalid),
        .out_valid(out_valid), .out_tag(out_tag), .out_len(out_len),
        .out_off(out_off), .out_lit(out_lit)
    );

    typedef struct {
        int                        cyc;
        logic [PWS-1:0][1:0]       tag;
        logic [PWS-1:0][LEN_W-1:0] len;
        logic [PWS-1:0][OFF_W-1:0] off;
        logic [PWS-1:0][7:0]       lit;
    } exp_t;

    exp_t  q[$];
    string rq[$];
    int    cyc = 0;
    int    checks = 0;
    int    failures = 0;
    bit    finished = 1'b0;

    int              w_len [PWS];
    int              w_off [PWS];
    logic [7:0]      w_lit [PWS];
    bit              w_mv  [PWS];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clr_win();
        for (int i = 0; i < PWS; i++) begin
            w_len[i] = 0;
            w_off[i] = 16'h100 + i * 3;
            w_lit[i] = 8'h41 + 8'(i);
            w_mv[i]  = 1'b0;
        end
    endtask

    task automatic set_m(input int pos, input int len, input int off);
        w_mv[pos]  = 1'b1;
        w_len[pos] = len;
        w_off[pos] = off;
    endtask

    // reference resolver built from the requirements, then drive one window
    task automatic send(input string req);
        exp_t e;
        int   tl [PWS];
        int   cnt;
        for (int i = 0; i < PWS; i++) begin
            int c;
            c = w_mv[i] ? w_len[i] : 0;
            if (c > PWS - i) c = PWS - i;
            if (c < 4) c = 0;
            tl[i] = c;
        end
        cnt = 0;
        for (int i = 0; i < PWS; i++) begin
            e.lit[i] = w_lit[i];
            e.len[i] = '0;
            e.off[i] = '0;
            if (cnt > 0) begin
                e.tag[i] = 2'd0;
                cnt--;
            end else if (tl[i] == 0 || (i < PWS - 1 && tl[i+1] > tl[i])) begin
                e.tag[i] = 2'd1;
            end else begin
                e.tag[i] = 2'd2;
                e.len[i] = LEN_W'(tl[i]);
                e.off[i] = OFF_W'(w_off[i]);
                cnt = tl[i] - 1;
            end
        end
        @(negedge clk);
        for (int i = 0; i < PWS; i++) begin
            in_lit[i]    = w_lit[i];
            in_len[i]    = LEN_W'(w_len[i]);
            in_off[i]    = OFF_W'(w_off[i]);
            in_mvalid[i] = w_mv[i];
        end
        in_valid = 1'b1;
        e.cyc = cyc;
        q.push_back(e);
        rq.push_back(req);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // monitor: pop the scoreboard whenever a resolved window appears
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R7", "out_valid with nothing pending", 128'(out_valid), 128'(0));
            end else begin
                exp_t  e;
                string r;
                e = q.pop_front();
                r = rq.pop_front();
                chk(cyc - e.cyc == LAT, "R7", "latency", 128'(cyc - e.cyc), 128'(LAT));
                chk(out_tag == e.tag, r, "tags", 128'(out_tag), 128'(e.tag));
                chk(out_len == e.len, {r, "/R6"}, "lengths", 128'(out_len), 128'(e.len));
                chk(out_off == e.off, {r, "/R6"}, "offsets", 128'(out_off), 128'(e.off));
                chk(out_lit == e.lit, "R6", "literals", 128'(out_lit), 128'(e.lit));
            end
        end
    end

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "R7", "watchdog expired", 128'(q.size()), 128'(0));
            report();
        end
    end

    initial begin
        clr_win();
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R8", "out_valid in reset", 128'(out_valid), 128'(0));
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R8", "out_valid after reset", 128'(out_valid), 128'(0));

        // R2: no candidates at all, every position is a literal
        clr_win();
        send("R2");
        idle(2);

        // R1: candidate at position 0 overshoots the window, trimmed to 8; R4 covers the rest
        clr_win();
        set_m(0, 20, 16'h0777);
        set_m(3, 5, 16'h0033);
        send("R1");
        idle(2);

        // R5: next position strictly longer, position 0 defers to a literal
        clr_win();
        set_m(0, 4, 16'h0010);
        set_m(1, 6, 16'h0020);
        send("R5");
        idle(2);

        // R5: tie keeps current match; R2: later length-3 candidate becomes literal
        clr_win();
        set_m(0, 5, 16'h0011);
        set_m(1, 5, 16'h0022);
        set_m(5, 3, 16'h0055);
        send("R5");
        idle(2);

        // R3: first window ends inside a match, the next one arrives right after
        clr_win();
        set_m(4, 9, 16'h0404);
        send("R3");
        clr_win();
        set_m(0, 4, 16'h0505);
        set_m(6, 10, 16'h0606);
        send("R3");
        idle(2);

        // R2: trimming shrinks a long candidate at position 6 below the minimum
        clr_win();
        set_m(6, 30, 16'h0666);
        set_m(0, 3, 16'h0001);
        send("R2");
        idle(2);

        // R4: a match ends and the very next position starts a fresh match
        clr_win();
        set_m(0, 4, 16'h0100);
        set_m(2, 6, 16'h0200);
        set_m(4, 4, 16'h0300);
        send("R4");
        idle(2);

        // R4/R5 mix: pseudo-random windows back to back
        for (int n = 0; n < 40; n++) begin
            clr_win();
            for (int i = 0; i < PWS; i++) begin
                if ($urandom_range(0, 2) != 0) set_m(i, int'($urandom_range(0, 15)), int'($urandom_range(1, 65535)));
                w_lit[i] = 8'($urandom_range(0, 255));
            end
            send("R4");
        end
        idle(LAT + 4);

        chk(q.size() == 0, "R7", "windows still pending", 128'(q.size()), 128'(0));
        finished = 1'b1;
        report();
    end

endmodule